// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block paces instruction flow for a small microcontroller core. Every input clock edge advances a phase state machine through four phases, Q1 to Q4. Four phases make one instruction cycle. The phases are given out as one-hot enables in the same clock domain, so there are no derived clocks. A program counter addresses the program memory for a whole cycle. At the edge that closes Q4, the addressed word is captured into the instruction register, and the counter moves on. The word captured in one cycle is executed during the next cycle, so fetch and execute overlap as a two-stage pipeline.

The execution unit sees the instruction register and a live flag. It also receives an operand-read strobe in Q2 and a result-write strobe in Q4. To take a jump, it raises the branch request with a target address. The sequencer acts on the request only at the close of Q4 in a live cycle. At that point it loads the target into the counter and discards the word already fetched, putting a no-operation in its place. The following cycle is therefore a bubble, and a taken branch costs two instruction cycles. A clock-out at one quarter of the input rate marks the cycle boundaries.

Two state machines set the behaviour. The phase machine has the states PH_Q1, PH_Q2, PH_Q3 and PH_Q4. Its only transition is an unconditional step to the next phase, with PH_Q4 wrapping back to PH_Q1. The pipeline machine has two states, PIPE_RUN and PIPE_BUBBLE:
- "take": PIPE_RUN goes to PIPE_BUBBLE when Q4 ends with a branch request.
- "refill": PIPE_BUBBLE always goes to PIPE_RUN at the end of Q4.
- "stay": PIPE_RUN stays in PIPE_RUN at the end of Q4 when there is no request.
- Reset enters PIPE_BUBBLE.

Top module: `qphase_sequencer`

## Requirements
- R1: A synchronous reset (rst_sync high at a clock edge) sets the following state:
  - phase_en is 4'b0001 (Q1);
  - pmem_addr is 0;
  - ir_word is NOP_WORD;
  - exec_live is 0;
  - clk_out is 1;
  - both strobes are 0.
- R2: Exactly one bit of phase_en is high at every edge. Bit i stands for phase Q(i+1), and the phases step Q1, Q2, Q3, Q4, Q1 on consecutive clocks.
- R3: clk_out is 1 during Q1 and Q2 and 0 during Q3 and Q4.
- R4: pmem_addr holds steady throughout an instruction cycle. Without a taken branch, it becomes the previous address plus one (modulo 2^ADDR_W) from the following Q1.
- R5: At the edge that ends Q4 without a taken branch, ir_word takes the pmem_data present at that edge and holds it for the next cycle. exec_live is 1 in that next cycle.
- R6: rd_strobe is high only in Q2 of a cycle with exec_live 1. wr_strobe is high only in Q4 of a cycle with exec_live 1. Both are high in those phases whenever exec_live is 1.
- R7: A branch is taken when br_req is high at the edge that ends Q4 of a live cycle. From the next Q1:
  - pmem_addr equals br_target;
  - ir_word equals NOP_WORD;
  - exec_live is 0 for that whole cycle, which suppresses both strobes.
- R8: br_req has no effect when it is high at the edges that end Q1, Q2 or Q3, or at the edge that ends Q4 of a bubble cycle.
- R9: The cycle after a bubble executes the word fetched from the branch target, with exec_live 1, and fetches from target plus one.
- R10: The first instruction cycle after reset is a bubble. Its strobes are low and it fetches from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input oscillator clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| pmem_addr | output | ADDR_W | Program memory fetch address (program counter) |
| pmem_data | input | INSTR_W | Program memory read word |
| br_req | input | 1 | Branch request from the execution unit |
| br_target | input | ADDR_W | Branch destination address |
| ir_word | output | INSTR_W | Instruction register, word being executed |
| exec_live | output | 1 | 1 when ir_word is a real instruction, 0 in a bubble |
| phase_en | output | 4 | One-hot phase enables, bit 0 = Q1 |
| rd_strobe | output | 1 | Operand-read strobe (Q2 of a live cycle) |
| wr_strobe | output | 1 | Result-write strobe (Q4 of a live cycle) |
| clk_out | output | 1 | Instruction-rate clock, high in Q1 and Q2 |

## Verification
If the phase machine stalls or skips a state, phase_en and clk_out show it on the next edge. The strobes then fall out of their slots within the same instruction cycle. A program counter or pipeline state that has gone wrong shows up at the next Q1 in three ways: pmem_addr is off, ir_word differs from the memory word at the previous address, or exec_live disagrees with the branch history. A reference model checks every output on every clock, so any such fault is reported within at most four clocks.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PHASE_W    = $clog2(NUM_PHASES);

    typedef enum logic [PHASE_W-1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    typedef enum logic {
        PIPE_BUBBLE = 1'b0,
        PIPE_RUN    = 1'b1
    } pipe_t;

endpackage

// File: rtl/qseq_phase_fsm.sv
module qseq_phase_fsm
    import qseq_pkg::*;
(
    input  logic                  clk_in,
    input  logic                  rst_sync,
    output logic [NUM_PHASES-1:0] phase_en,
    output logic                  clk_out,
    output logic                  cyc_end
);

    phase_t phase_q;
    phase_t phase_d;
    logic   clk_out_q;

    // state register
    always_ff @(posedge clk_in) begin
        if (rst_sync) begin
            phase_q   <= PH_Q1;
            clk_out_q <= 1'b1;
        end else begin
            phase_q   <= phase_d;
            clk_out_q <= (phase_d == PH_Q1) || (phase_d == PH_Q2);
        end
    end

    // next phase: unconditional step
    always_comb begin
        phase_d = PH_Q1;
        unique case (phase_q)
            PH_Q1: phase_d = PH_Q2;
            PH_Q2: phase_d = PH_Q3;
            PH_Q3: phase_d = PH_Q4;
            PH_Q4: phase_d = PH_Q1;
            default: phase_d = PH_Q1;
        endcase
    end

    // one-hot enables
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase_en
        assign phase_en[g] = (phase_q == phase_t'(g));
    end

    assign cyc_end = (phase_q == PH_Q4);
    assign clk_out = clk_out_q;

endmodule

// File: rtl/qseq_pipe_ctl.sv
module qseq_pipe_ctl
    import qseq_pkg::*;
(
    input  logic clk_in,
    input  logic rst_sync,
    input  logic cyc_end,
    input  logic br_req,
    output logic exec_live,
    output logic take_branch,
    output logic load_word
);

    pipe_t pipe_q;
    pipe_t pipe_d;

    always_ff @(posedge clk_in) begin
        if (rst_sync) begin
            pipe_q <= PIPE_BUBBLE;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        pipe_d = pipe_q;
        unique case (pipe_q)
            PIPE_RUN: begin
                if (cyc_end && br_req) begin
                    pipe_d = PIPE_BUBBLE;   // take
                end else begin
                    pipe_d = PIPE_RUN;      // stay
                end
            end
            PIPE_BUBBLE: begin
                if (cyc_end) begin
                    pipe_d = PIPE_RUN;      // refill
                end
            end
            default: pipe_d = PIPE_BUBBLE;
        endcase
    end

    // outputs
    always_comb begin
        exec_live   = (pipe_q == PIPE_RUN);
        take_branch = cyc_end && br_req && (pipe_q == PIPE_RUN);
        load_word   = cyc_end && !take_branch;
    end

endmodule

// File: rtl/qseq_fetch.sv
module qseq_fetch #(
    parameter int unsigned              ADDR_W    = 11,
    parameter int unsigned              INSTR_W   = 14,
    parameter logic [INSTR_W-1:0]       NOP_WORD  = '0,
    parameter logic [ADDR_W-1:0]        RESET_VEC = '0
) (
    input  logic               clk_in,
    input  logic               rst_sync,
    input  logic               load_word,
    input  logic               take_branch,
    input  logic [ADDR_W-1:0]  br_target,
    input  logic [INSTR_W-1:0] pmem_data,
    output logic [ADDR_W-1:0]  pc,
    output logic [INSTR_W-1:0] ir
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0]  pc_q;
    logic [INSTR_W-1:0] ir_q;

    always_ff @(posedge clk_in) begin
        if (rst_sync) begin
            pc_q <= RESET_VEC;
            ir_q <= NOP_WORD;
        end else if (take_branch) begin
            pc_q <= br_target;
            ir_q <= NOP_WORD;
        end else if (load_word) begin
            pc_q <= pc_q + PC_STEP;
            ir_q <= pmem_data;
        end
    end

    assign pc = pc_q;
    assign ir = ir_q;

endmodule

// File: rtl/qphase_sequencer.sv
module qphase_sequencer
    import qseq_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 11,
    parameter int unsigned        INSTR_W   = 14,
    parameter logic [INSTR_W-1:0] NOP_WORD  = '0,
    parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
    input  logic               clk_in,
    input  logic               rst_sync,
    output logic [ADDR_W-1:0]  pmem_addr,
    input  logic [INSTR_W-1:0] pmem_data,
    input  logic               br_req,
    input  logic [ADDR_W-1:0]  br_target,
    output logic [INSTR_W-1:0] ir_word,
    output logic               exec_live,
    output logic [3:0]         phase_en,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               clk_out
);

    localparam int unsigned RD_SLOT = 1;   // Q2
    localparam int unsigned WR_SLOT = NUM_PHASES - 1; // Q4

    logic cyc_end;
    logic take_branch;
    logic load_word;
    logic live;

    qseq_phase_fsm u_phase (
        .clk_in   (clk_in),
        .rst_sync (rst_sync),
        .phase_en (phase_en),
        .clk_out  (clk_out),
        .cyc_end  (cyc_end)
    );

    qseq_pipe_ctl u_pipe (
        .clk_in      (clk_in),
        .rst_sync    (rst_sync),
        .cyc_end     (cyc_end),
        .br_req      (br_req),
        .exec_live   (live),
        .take_branch (take_branch),
        .load_word   (load_word)
    );

    qseq_fetch #(
        .ADDR_W    (ADDR_W),
        .INSTR_W   (INSTR_W),
        .NOP_WORD  (NOP_WORD),
        .RESET_VEC (RESET_VEC)
    ) u_fetch (
        .clk_in      (clk_in),
        .rst_sync    (rst_sync),
        .load_word   (load_word),
        .take_branch (take_branch),
        .br_target   (br_target),
        .pmem_data   (pmem_data),
        .pc          (pmem_addr),
        .ir          (ir_word)
    );

    assign exec_live = live;
    assign rd_strobe = live && phase_en[RD_SLOT];
    assign wr_strobe = live && phase_en[WR_SLOT];

endmodule

// File: rtl/qseq_checker.sv
module qseq_checker #(
    parameter int unsigned        ADDR_W   = 11,
    parameter int unsigned        INSTR_W  = 14,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
    input logic               clk_in,
    input logic               rst_sync,
    input logic [ADDR_W-1:0]  pmem_addr,
    input logic [INSTR_W-1:0] pmem_data,
    input logic               br_req,
    input logic [ADDR_W-1:0]  br_target,
    input logic [INSTR_W-1:0] ir_word,
    input logic               exec_live,
    input logic [3:0]         phase_en,
    input logic               rd_strobe,
    input logic               wr_strobe,
    input logic               clk_out
);

    a_r2_one_phase: assert property (@(posedge clk_in) disable iff (rst_sync)
        $countones(phase_en) == 1);

    a_r2_q4_to_q1: assert property (@(posedge clk_in) disable iff (rst_sync)
        phase_en[3] |=> phase_en[0]);

    a_r2_q1_to_q2: assert property (@(posedge clk_in) disable iff (rst_sync)
        phase_en[0] |=> phase_en[1]);

    a_r3_clkout: assert property (@(posedge clk_in) disable iff (rst_sync)
        clk_out == (phase_en[0] || phase_en[1]));

    a_r4_addr_hold: assert property (@(posedge clk_in) disable iff (rst_sync)
        !phase_en[0] |-> $stable(pmem_addr));

    a_r4_addr_step: assert property (@(posedge clk_in) disable iff (rst_sync)
        (phase_en[3] && !(br_req && exec_live)) |=>
            pmem_addr == ADDR_W'($past(pmem_addr) + 1'b1));

    a_r5_ir_load: assert property (@(posedge clk_in) disable iff (rst_sync)
        (phase_en[3] && !(br_req && exec_live)) |=>
            (ir_word == $past(pmem_data) && exec_live));

    a_r6_rd_slot: assert property (@(posedge clk_in) disable iff (rst_sync)
        rd_strobe |-> (phase_en[1] && exec_live));

    a_r6_wr_slot: assert property (@(posedge clk_in) disable iff (rst_sync)
        wr_strobe |-> (phase_en[3] && exec_live));

    a_r7_branch: assert property (@(posedge clk_in) disable iff (rst_sync)
        (phase_en[3] && br_req && exec_live) |=>
            (pmem_addr == $past(br_target) && ir_word == NOP_WORD && !exec_live));

    a_r9_refill: assert property (@(posedge clk_in) disable iff (rst_sync)
        (phase_en[3] && !exec_live) |=> exec_live);

endmodule

bind qphase_sequencer qseq_checker #(
    .ADDR_W   (ADDR_W),
    .INSTR_W  (INSTR_W),
    .NOP_WORD (NOP_WORD)
) u_chk (
    .clk_in    (clk_in),
    .rst_sync  (rst_sync),
    .pmem_addr (pmem_addr),
    .pmem_data (pmem_data),
    .br_req    (br_req),
    .br_target (br_target),
    .ir_word   (ir_word),
    .exec_live (exec_live),
    .phase_en  (phase_en),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .clk_out   (clk_out)
);

// File: tb/tb_qphase_sequencer.sv
module tb_qphase_sequencer;

    localparam int AW = 11;
    localparam int IW = 14;
    localparam logic [IW-1:0] NOP = '0;
    localparam int AMASK = (1 << AW) - 1;
    localparam int RUN_CYCLES = 3000;

    logic          clk = 1'b0;
    logic          rst_sync;
    logic [AW-1:0] pmem_addr;
    logic [IW-1:0] pmem_data;
    logic          br_req;
    logic [AW-1:0] br_target;
    logic [IW-1:0] ir_word;
    logic          exec_live;
    logic [3:0]    phase_en;
    logic          rd_strobe;
    logic          wr_strobe;
    logic          clk_out;

    always #10 clk = ~clk;

    function automatic logic [IW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a[2:0], a} ^ 14'h1A5C;
    endfunction

    assign pmem_data = mem_fn(pmem_addr);

    qphase_sequencer dut (
        .clk_in    (clk),
        .rst_sync  (rst_sync),
        .pmem_addr (pmem_addr),
        .pmem_data (pmem_data),
        .br_req    (br_req),
        .br_target (br_target),
        .ir_word   (ir_word),
        .exec_live (exec_live),
        .phase_en  (phase_en),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .clk_out   (clk_out)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model state
    int          m_ph;
    int          m_pc;
    logic [IW-1:0] m_ir;
    bit          m_live;
    int          k;
    string       addr_tag;
    string       live_tag;
    string       ir_tag;

    task automatic model_reset();
        m_ph = 0; m_pc = 0; m_ir = NOP; m_live = 0;
        addr_tag = "R1"; live_tag = "R10"; ir_tag = "R1";
    endtask

    task automatic compare_all();
        logic [3:0] exp_ph;
        exp_ph = 4'(1 << m_ph);
        chk(phase_en == exp_ph, "R2", "phase_en", phase_en, exp_ph);
        chk(clk_out == (m_ph < 2), "R3", "clk_out", clk_out, (m_ph < 2));
        chk(pmem_addr == AW'(m_pc), addr_tag, "pmem_addr", pmem_addr, m_pc);
        chk(ir_word == m_ir, ir_tag, "ir_word", ir_word, m_ir);
        chk(exec_live == m_live, live_tag, "exec_live", exec_live, m_live);
        chk(rd_strobe == (m_live && m_ph == 1), "R6", "rd_strobe", rd_strobe,
            (m_live && m_ph == 1));
        chk(wr_strobe == (m_live && m_ph == 3), "R6", "wr_strobe", wr_strobe,
            (m_live && m_ph == 3));
    endtask

    task automatic model_step(input bit rst, input bit br, input int tgt);
        bit taken;
        if (rst) begin
            model_reset();
            return;
        end
        taken = (m_ph == 3) && m_live && br;
        if (m_ph == 3) begin
            if (taken) begin
                m_pc = tgt & AMASK; m_ir = NOP; m_live = 0;
                addr_tag = "R7"; ir_tag = "R7"; live_tag = "R7";
            end else begin
                ir_tag   = m_live ? "R5" : "R9";
                live_tag = m_live ? "R5" : "R9";
                addr_tag = br ? "R8" : "R4";
                m_ir = mem_fn(AW'(m_pc)); m_pc = (m_pc + 1) & AMASK; m_live = 1;
            end
            k++;
        end else if (br) begin
            addr_tag = "R8";
        end
        m_ph = (m_ph + 1) % 4;
    endtask

    initial begin
        rst_sync = 1'b1; br_req = 1'b0; br_target = '0; k = 0;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(phase_en == 4'b0001, "R1", "phase_en", phase_en, 1);
        chk(pmem_addr == '0, "R1", "pmem_addr", pmem_addr, 0);
        chk(ir_word == NOP, "R1", "ir_word", ir_word, NOP);
        chk(exec_live == 1'b0, "R1", "exec_live", exec_live, 0);
        chk(clk_out == 1'b1, "R1", "clk_out", clk_out, 1);
        chk(!rd_strobe && !wr_strobe, "R1", "strobes", {rd_strobe, wr_strobe}, 0);
        model_step(1'b1, 1'b0, 0);
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            bit r;
            bit b;
            int t;
            r = (cyc >= 1500 && cyc < 1503);
            b = 0; t = (k * 13) & AMASK;
            if (k == 40) begin
                b = 1; t = 'h7FF;                 // R4 wrap after branch
            end else if (k % 7 == 3) begin
                b = 1; t = (k * 37) & AMASK;      // R7 taken branch
            end else if (k % 7 == 4) begin
                b = 1; t = 'h123;                 // R8 request during bubble
            end else if (k % 11 == 5 && m_ph != 3) begin
                b = 1; t = 'h555;                 // R8 request outside Q4
            end
            rst_sync  = r;
            br_req    = b;
            br_target = AW'(t);
            #1;
            compare_all();
            model_step(r, b, t);
            @(negedge clk);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule